// File: doc/BRIEF.md
# Event Interrupt Aggregator

This block gathers 24 single-bit event inputs into three 8-bit status bytes and drives one level-sensitive interrupt line towards a host processor. Each source has two mask bits. The capture mask decides whether an event is recorded in status at all. The output mask decides whether a recorded event may assert the interrupt line. Software reaches every register through a byte-wide register port that has a burst pointer, so a block of consecutive registers can be read or written one strobe after another without resending the address.

Clearing works on the whole group. A write of any value to any one of the three status addresses wipes all 24 status bits in a single cycle. A typical service routine therefore reads the three status bytes in one burst, handles the pending sources, and then issues one write to a status address to acknowledge everything at once. An event that arrives in the same cycle as that write is not lost.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A status bit is set at the clock edge where its event input is high and its capture-mask bit is 0. Once set, it stays 1 until a group clear.
- R2: While a source's capture-mask bit is 1, its event input never sets its status bit.
- R3: `irq_out` is a registered level. In the cycle after the edge at which some status bit is 1 and its output-mask bit is 0, it is high. Otherwise it is low.
- R4: A write strobe, of any data value, to status address 0, 1 or 2 clears all 24 status bits at that edge.
- R5: If an unmasked event is present at the same edge as a clear write, its status bit is 1 after that edge.
- R6: Source 23 is reserved. Its status bit (bit 7 of status byte C) always reads 0 and never latches an event.
- R7: After reset, all status bits are 0, all six mask bytes read 0xFF, `irq_out` is 0 and `reg_rdata` is 0.
- R8: The mask bytes are read/write and return the last value written. A status read leaves the status contents unchanged.
- R9: When `reg_start` is high, a strobe uses `reg_addr`. When it is low, the strobe uses the address that follows the previous strobe's address, so consecutive strobes walk upward through the map.
- R10: The address map is as follows. Addresses 0, 1 and 2 hold status bytes A, B and C, which carry sources 0–7, 8–15 and 16–23 with the LSB as the lowest source. Addresses 3–5 hold the output masks and addresses 6–8 hold the capture masks, in the same A/B/C order. A mask bit of 1 masks its source. Other addresses read 0 and ignore writes. Read data is registered: it appears after the edge that samples `reg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 24 | Event inputs, one per source |
| reg_start | input | 1 | Start of access; the strobe uses `reg_addr` |
| reg_addr | input | 4 | Register address, taken when `reg_start` is high |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Interrupt line to the host, active high |

## Verification
The in-design assertions run on every cycle. They cover stickiness of status bits, blocking by the capture mask, the effect of a clear write and the priority of a simultaneous event over it, the reserved bit staying at 0, mask write-back, pointer advance during bursts, and the rule that the interrupt only rises after an unmasked pending bit. Other behaviours can only be shown by the bench scenarios: reset values read through the port, the full address map, the fact that the clear ignores its data byte, unmapped addresses, and a long mixed run of events, bursts and clears. In that run every output is compared against a behavioural model on every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  typedef enum logic [1:0] {
    RGN_STS   = 2'd0,
    RGN_OMASK = 2'd1,
    RGN_CMASK = 2'd2,
    RGN_NONE  = 2'd3
  } region_e;

  // Region of an address: status bytes first, then output masks, then capture masks.
  function automatic region_e addr_region(input int unsigned a, input int unsigned ngrp);
    if (a < ngrp)          return RGN_STS;
    else if (a < 2 * ngrp) return RGN_OMASK;
    else if (a < 3 * ngrp) return RGN_CMASK;
    else                   return RGN_NONE;
  endfunction

  // Byte index inside a region.
  function automatic int unsigned addr_group(input int unsigned a, input int unsigned ngrp);
    if (a < 3 * ngrp) return a % ngrp;
    else              return 0;
  endfunction

endpackage

// File: rtl/evt_bus_ptr.sv
module evt_bus_ptr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0] ptr_q;
  logic              strobe;

  assign strobe   = rd | wr;
  assign acc_addr = start ? addr : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (strobe) ptr_q <= acc_addr + 1'b1;
  end

  // R9: a continuation strobe lands one address above the previous one
  assert_burst_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (start || (acc_addr == $past(acc_addr) + 1'b1)));

endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int              NGRP   = 3,
  parameter int              GRP_W  = 8,
  parameter int              GIDX_W = 2,
  parameter logic [GRP_W-1:0] RST_VAL = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [GIDX_W-1:0]       wr_grp,
  input  logic [GRP_W-1:0]        wdata,
  output logic [NGRP*GRP_W-1:0]   bits
);
  for (genvar g = 0; g < NGRP; g++) begin : g_byte
    logic [GRP_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= RST_VAL;
      else if (wr_en && wr_grp == GIDX_W'(g))      q <= wdata;
    end
    assign bits[g*GRP_W +: GRP_W] = q;
  end

  // R8: a written byte returns the written value on the next cycle
  assert_mask_writeback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bits[$past(wr_grp)*GRP_W +: GRP_W] == $past(wdata)));

  // R8: without a write strobe no mask bit moves
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits));

endmodule

// File: rtl/evt_status_latch.sv
module evt_status_latch #(
  parameter int              NSRC = 24,
  parameter logic [NSRC-1:0] RSVD = 24'h800000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] cmask,
  input  logic            clr_all,
  output logic [NSRC-1:0] sts
);
  logic [NSRC-1:0] evt_hit;
  logic [NSRC-1:0] sts_kept;
  logic [NSRC-1:0] sts_d;

  assign evt_hit  = evt & ~cmask & ~RSVD;
  assign sts_kept = clr_all ? '0 : sts;
  assign sts_d    = sts_kept | evt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= sts_d;
  end

  // R1: without a clear, set bits stay set
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((sts & $past(sts)) == $past(sts)));

  // R2: newly set bits had an event with the capture mask open
  assert_capture_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~($past(evt) & ~$past(cmask))) == '0));

  // R4: after a clear only same-cycle events remain
  assert_group_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ((sts & ~($past(evt) & ~$past(cmask))) == '0));

  // R5: an event coinciding with a clear survives
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ((sts & $past(evt_hit)) == $past(evt_hit)));

  // R6: reserved positions never hold a 1
  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & RSVD) == '0);

endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] sts,
  input  logic [NSRC-1:0] omask,
  output logic            irq
);
  logic irq_cause;

  assign irq_cause = |(sts & ~omask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_cause;
  end

  // R3: the line rises only after an unmasked pending bit was seen
  assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(sts & ~omask)));

  // R3: the line drops only after no unmasked bit was pending
  assert_irq_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> !$past(|(sts & ~omask)));

endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator #(
  parameter int                NSRC   = 24,
  parameter int                GRP_W  = 8,
  parameter int                ADDR_W = 4,
  parameter logic [NSRC-1:0]   RSVD   = 24'h800000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_in,
  input  logic              reg_start,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [GRP_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  input  logic              reg_wr,
  output logic [GRP_W-1:0]  reg_rdata,
  output logic              irq_out
);
  import evt_irq_pkg::*;

  localparam int NGRP   = NSRC / GRP_W;
  localparam int GIDX_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic [ADDR_W-1:0] acc_addr;
  region_e           rgn;
  logic [GIDX_W-1:0] grp;
  logic              clr_all;
  logic              om_we;
  logic              cm_we;
  logic [NSRC-1:0]   sts;
  logic [NSRC-1:0]   omask;
  logic [NSRC-1:0]   cmask;
  logic [GRP_W-1:0]  rd_val;

  evt_bus_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start(reg_start), .addr(reg_addr),
    .rd(reg_rd), .wr(reg_wr), .acc_addr(acc_addr)
  );

  assign rgn     = addr_region(32'(acc_addr), NGRP);
  assign grp     = GIDX_W'(addr_group(32'(acc_addr), NGRP));
  assign clr_all = reg_wr && (rgn == RGN_STS);
  assign om_we   = reg_wr && (rgn == RGN_OMASK);
  assign cm_we   = reg_wr && (rgn == RGN_CMASK);

  evt_mask_bank #(.NGRP(NGRP), .GRP_W(GRP_W), .GIDX_W(GIDX_W)) u_omask (
    .clk(clk), .rst_n(rst_n), .wr_en(om_we), .wr_grp(grp),
    .wdata(reg_wdata), .bits(omask)
  );

  evt_mask_bank #(.NGRP(NGRP), .GRP_W(GRP_W), .GIDX_W(GIDX_W)) u_cmask (
    .clk(clk), .rst_n(rst_n), .wr_en(cm_we), .wr_grp(grp),
    .wdata(reg_wdata), .bits(cmask)
  );

  evt_status_latch #(.NSRC(NSRC), .RSVD(RSVD)) u_sts (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .cmask(cmask),
    .clr_all(clr_all), .sts(sts)
  );

  evt_irq_gen #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .sts(sts), .omask(omask), .irq(irq_out)
  );

  always_comb begin
    unique case (rgn)
      RGN_STS:   rd_val = sts[grp*GRP_W +: GRP_W];
      RGN_OMASK: rd_val = omask[grp*GRP_W +: GRP_W];
      RGN_CMASK: rd_val = cmask[grp*GRP_W +: GRP_W];
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  // R8: a status read without a write leaves the pending set intact
  assert_read_no_side_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> ((sts & $past(sts)) == $past(sts)));

  // R10: unmapped reads return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && rgn == RGN_NONE) |=> (reg_rdata == '0));

endmodule

// File: tb/tb_evt_irq_aggregator.sv
module tb_evt_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] evt_in = '0;
  logic        reg_start = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_rdata;
  logic        irq_out;

  always #4 clk = ~clk;

  evt_irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_start(reg_start),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // behavioural reference state
  bit [23:0] m_sts;
  bit [7:0]  m_om [3];
  bit [7:0]  m_cm [3];
  bit        m_irq;
  bit [7:0]  m_rd;
  int        m_ptr;
  int        vectors = 0;
  int        miscompares = 0;
  bit        done = 1'b0;
  string     cur_req = "R7";

  function automatic bit [23:0] pack3(input bit [7:0] b0, input bit [7:0] b1, input bit [7:0] b2);
    return {b2, b1, b0};
  endfunction

  function automatic bit [7:0] model_read(input int a);
    bit [23:0] s;
    s = m_sts;
    if (a < 3)      return s[a*8 +: 8];
    else if (a < 6) return m_om[a-3];
    else if (a < 9) return m_cm[a-6];
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_sts = '0; m_irq = 0; m_rd = '0; m_ptr = 0;
    for (int i = 0; i < 3; i++) begin m_om[i] = 8'hFF; m_cm[i] = 8'hFF; end
  endtask

  task automatic model_step();
    int        a;
    bit [23:0] om_all, cm_all, hit;
    bit [7:0]  rv;
    a      = reg_start ? int'(reg_addr) : m_ptr;
    om_all = pack3(m_om[0], m_om[1], m_om[2]);
    cm_all = pack3(m_cm[0], m_cm[1], m_cm[2]);
    rv     = model_read(a);
    m_irq  = (m_sts & ~om_all) != 0;
    hit    = evt_in & ~cm_all & 24'h7FFFFF;
    if (reg_wr && a < 3) m_sts = '0;
    m_sts = m_sts | hit;
    if (reg_wr && a >= 3 && a < 6) m_om[a-3] = reg_wdata;
    if (reg_wr && a >= 6 && a < 9) m_cm[a-6] = reg_wdata;
    if (reg_rd) m_rd = rv;
    if (reg_rd || reg_wr) m_ptr = (a + 1) % 16;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    chk("R3", "irq_out", int'(irq_out), int'(m_irq));
    chk(cur_req, "reg_rdata", int'(reg_rdata), int'(m_rd));
  endtask

  task automatic op(input bit st, input int a, input bit [7:0] d, input bit rd, input bit wr, input bit [23:0] ev);
    reg_start = st; reg_addr = 4'(a); reg_wdata = d; reg_rd = rd; reg_wr = wr; evt_in = ev;
    tick();
    reg_start = 0; reg_rd = 0; reg_wr = 0; evt_in = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 8'h00, 0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "irq after reset", int'(irq_out), 0);
    chk("R7", "rdata after reset", int'(reg_rdata), 0);
    rst_n = 1'b1;

    // R7/R10: read whole map as one burst
    cur_req = "R7";
    op(1, 0, 8'h00, 1, 0, '0);
    chk("R7", "status A reset", int'(reg_rdata), 8'h00);
    op(0, 0, 8'h00, 1, 0, '0);
    op(0, 0, 8'h00, 1, 0, '0);
    op(0, 0, 8'h00, 1, 0, '0);
    chk("R7", "output mask A reset", int'(reg_rdata), 8'hFF);
    for (int i = 0; i < 5; i++) op(0, 0, 8'h00, 1, 0, '0);
    chk("R7", "capture mask C reset", int'(reg_rdata), 8'hFF);

    // R2: all events with capture masks closed
    cur_req = "R2";
    op(0, 0, 8'h00, 0, 0, 24'hFFFFFF);
    op(1, 0, 8'h00, 1, 0, '0);
    chk("R2", "status A masked", int'(reg_rdata), 8'h00);

    // R9/R10: burst writes of capture masks then output masks
    cur_req = "R9";
    op(1, 6, 8'h00, 0, 1, '0);
    op(0, 0, 8'h00, 0, 1, '0);
    op(0, 0, 8'h00, 0, 1, '0);
    op(1, 3, 8'hFE, 0, 1, '0);
    op(0, 0, 8'hFF, 0, 1, '0);
    op(0, 0, 8'h7F, 0, 1, '0);
    op(1, 5, 8'h00, 1, 0, '0);
    chk("R9", "output mask C via burst", int'(reg_rdata), 8'h7F);
    cur_req = "R8";
    op(1, 7, 8'h00, 1, 0, '0);
    chk("R8", "capture mask B readback", int'(reg_rdata), 8'h00);

    // R1: a one-cycle pulse on source 5 sticks, output stays masked
    cur_req = "R1";
    op(0, 0, 8'h00, 0, 0, 24'h000020);
    idle(3);
    op(1, 0, 8'h00, 1, 0, '0);
    chk("R1", "status A sticky", int'(reg_rdata), 8'h20);
    chk("R3", "irq with masked bit", int'(irq_out), 0);

    // R3: source 0 unmasked at output
    cur_req = "R3";
    op(0, 0, 8'h00, 0, 0, 24'h000001);
    idle(1);
    chk("R3", "irq unmasked bit", int'(irq_out), 1);

    // R6: reserved source 23
    cur_req = "R6";
    op(0, 0, 8'h00, 0, 0, 24'h800000);
    op(1, 2, 8'h00, 1, 0, '0);
    chk("R6", "status C reserved", int'(reg_rdata), 8'h00);

    // R8: repeated status read has no side effect
    cur_req = "R8";
    op(1, 0, 8'h00, 1, 0, '0);
    op(1, 0, 8'h00, 1, 0, '0);
    chk("R8", "status A reread", int'(reg_rdata), 8'h21);

    // R4: write of arbitrary value to status B clears all
    cur_req = "R4";
    op(0, 0, 8'h00, 0, 0, 24'h410000);
    op(1, 1, 8'h5A, 0, 1, '0);
    idle(1);
    chk("R4", "irq after clear", int'(irq_out), 0);
    op(1, 0, 8'h00, 1, 0, '0);
    chk("R4", "status A cleared", int'(reg_rdata), 8'h00);
    op(0, 0, 8'h00, 1, 0, '0);
    op(0, 0, 8'h00, 1, 0, '0);
    chk("R4", "status C cleared", int'(reg_rdata), 8'h00);

    // R5: event at the clear edge survives
    cur_req = "R5";
    op(0, 0, 8'h00, 0, 0, 24'h000010);
    op(1, 2, 8'hA5, 0, 1, 24'h000004);
    op(1, 0, 8'h00, 1, 0, '0);
    chk("R5", "status A event wins", int'(reg_rdata), 8'h04);

    // R10: unmapped address ignores writes and reads zero
    cur_req = "R10";
    op(1, 12, 8'h33, 0, 1, '0);
    op(1, 12, 8'h00, 1, 0, '0);
    chk("R10", "unmapped read", int'(reg_rdata), 8'h00);

    // mixed run against the model
    cur_req = "R1";
    for (int i = 0; i < 600; i++) begin
      int        k;
      bit [23:0] ev;
      k  = $urandom % 16;
      ev = ($urandom % 4 == 0) ? 24'($urandom) : 24'h0;
      if (k == 0)      op(1, $urandom % 3, 8'($urandom), 0, 1, ev);
      else if (k < 3)  op(1, 3 + $urandom % 6, 8'($urandom), 0, 1, ev);
      else if (k < 7)  op(($urandom % 2) == 1, $urandom % 10, 8'h00, 1, 0, ev);
      else             op(0, 0, 8'h00, 0, 0, ev);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule